// File: doc/BRIEF.md
# Integer-N synthesizer divider chain

This block is the digital core of a dual-band local-oscillator synthesizer. One sampling clock runs all of its logic. Two single-cycle enables arrive on that clock. The first marks each period of the 26 MHz crystal reference. The second marks each output pulse of an external 64/65 dual-modulus prescaler that divides the VCO.

The reference is divided by 65 to make a 400 kHz comparison event. The feedback path has a swallow count A and a main count N. The modulus-control output asks for divide-by-65 during the first A prescaler pulses of every N-pulse cycle. The total VCO division is therefore 64·N + A.

A phase-frequency detector compares the two divided edges and drives up and down commands to an external charge pump. A lock detector watches how wide those commands are. A channel calculator turns band, transmit/receive and channel index into N and A. It also chooses the mixer post-divider: divide-by-4 in the low band, where the VCO runs at four times the channel frequency, and divide-by-2 in the high band, where it runs at twice. A one-cycle retune strobe loads a new setting.

Top module: `synth_divider_chain`

## Requirements
- R1: A comparison event occurs once every 65 `ref_tick` pulses. After reset the first event follows the 65th tick, one cycle later.
- R2: The total division for a channel index `chan` is computed as follows. Low band (`band_hi`=0), receive: 9250 + 2·chan. Low band, transmit: 8800 + 2·chan. High band (`band_hi`=1), receive: 9025 + chan. High band, transmit: 8550 + chan.
- R3: A channel index above the band's last channel is clamped to that last channel before the total is computed. The last channel is 174 in the low band and 374 in the high band.
- R4: N is the total divided by 64 and A is the total modulo 64. After N `pre_tick` pulses, `fb_edge` is high for one cycle, in the cycle after the Nth pulse. `mod_hi` is 1 exactly during the first A pulses of each such cycle.
- R5: `lo_div4` is 1 after a retune to the low band and 0 after a retune to the high band. It changes only when `tune` is asserted and is 1 after reset.
- R6: `dn` is raised by a feedback edge and `up` by a comparison edge. When both are set, both clear on the same clock. A feedback edge that leads by k cycles gives a `dn` pulse k cycles wide. Coincident edges give no pulse. A feedback edge that lags gives an `up` pulse.
- R7: `tune` loads the new N, A and post-divider setting and starts a hold. The hold lasts until the next comparison event. During the hold, `up`, `dn` and `fb_edge` stay low and `pre_tick` is ignored. The feedback count restarts at that event.
- R8: A comparison is good when the total up/down high time since the previous event is below 4 cycles. `lock` rises after 16 consecutive good comparisons and not after 15.
- R9: `lock` falls at the first comparison whose up/down high time is 4 cycles or more. It also falls in the cycle after `tune`.
- R10: After reset, `up`, `dn`, `lock` and `fb_edge` are 0, `lo_div4` is 1, and `mod_hi` is 1. The divider holds the low-band receive setting for channel 0 (N=144, A=34).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse per crystal reference period |
| pre_tick | input | 1 | One-cycle pulse per prescaler output period |
| tune | input | 1 | One-cycle strobe that loads a new channel setting |
| band_hi | input | 1 | 0 selects the low band, 1 the high band |
| tx_sel | input | 1 | 1 selects the transmit frequency, 0 receive |
| chan | input | 9 | Channel index from the band's lowest channel |
| mod_hi | output | 1 | Prescaler modulus request: 1 for 65, 0 for 64 |
| fb_edge | output | 1 | One-cycle divided feedback edge |
| up | output | 1 | Charge-pump pump-up command |
| dn | output | 1 | Charge-pump pump-down command |
| lock | output | 1 | Loop-locked indication |
| lo_div4 | output | 1 | Mixer post-divider select: 1 for divide-by-4, 0 for divide-by-2 |

## Verification
The bench sets the feedback edge exactly on the comparison edge, then 3 cycles ahead, then 4 cycles ahead. A detector that missed its mutual clear, or measured width off by one, would show a pulse in the aligned case or misjudge where the threshold sits between 3 and 4. The lock count is checked at the 15th and 16th good comparison and again after a violation. This catches a counter that does not restart or that locks one comparison early. Totals are checked at the first and last channel of every band and direction, and with out-of-range indices. A wrong halving for the high band, a missing clamp, or a swapped N/A split changes the measured pulse counts. Prescaler pulses keep arriving during each retune hold, so a divider that ignored the hold would emit feedback edges there.

// File: rtl/synth_pkg.sv
package synth_pkg;

    typedef enum logic {
        BAND_LOW  = 1'b0,
        BAND_HIGH = 1'b1
    } band_e;

    typedef struct packed {
        logic up;
        logic dn;
    } pfd_cmd_t;

endpackage

// File: rtl/synth_chan_calc.sv
module synth_chan_calc #(
    parameter int CH_W     = 9,
    parameter int N_W      = 8,
    parameter int A_W      = 6,
    parameter int LAST_LO  = 174,
    parameter int LAST_HI  = 374,
    parameter int RX_LO    = 9250,
    parameter int TX_LO    = 8800,
    parameter int RX_HI    = 18050,
    parameter int TX_HI    = 17100
) (
    input  logic           band_hi,
    input  logic           tx_sel,
    input  logic [CH_W-1:0] chan,
    output logic [N_W-1:0]  n_val,
    output logic [A_W-1:0]  a_val,
    output logic            div4
);
    import synth_pkg::*;

    localparam int TOT_W = N_W + A_W;
    localparam int SUM_W = TOT_W + 1;

    band_e             band;
    logic [CH_W-1:0]   ch_lim;
    logic [SUM_W-1:0]  base;
    logic [SUM_W-1:0]  sum;
    logic [TOT_W-1:0]  total;

    always_comb begin
        band = band_e'(band_hi);
        if (band == BAND_HIGH) begin
            ch_lim = (chan > CH_W'(LAST_HI)) ? CH_W'(LAST_HI) : chan;
        end else begin
            ch_lim = (chan > CH_W'(LAST_LO)) ? CH_W'(LAST_LO) : chan;
        end
        case ({band == BAND_HIGH, tx_sel})
            2'b00:   base = SUM_W'(RX_LO);
            2'b01:   base = SUM_W'(TX_LO);
            2'b10:   base = SUM_W'(RX_HI);
            default: base = SUM_W'(TX_HI);
        endcase
        // LO in 100 kHz units plus two units per 200 kHz channel
        sum = base + {{(SUM_W-CH_W-1){1'b0}}, ch_lim, 1'b0};
        // low band: VCO = 4*LO, so the total equals LO/100k; high band halves it
        total = (band == BAND_HIGH) ? sum[SUM_W-1:1] : sum[TOT_W-1:0];
        n_val = total[TOT_W-1:A_W];
        a_val = total[A_W-1:0];
        div4  = (band == BAND_LOW);
    end

endmodule

// File: rtl/synth_ref_div.sv
module synth_ref_div #(
    parameter int DIV = 65
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic cmp_edge
);
    localparam int CW = $clog2(DIV);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          edge_hit;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.edge_hit = 1'b0;
        if (tick) begin
            if (st_q.cnt == CW'(DIV - 1)) begin
                st_d.cnt      = '0;
                st_d.edge_hit = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp_edge = st_q.edge_hit;

endmodule

// File: rtl/synth_fb_div.sv
module synth_fb_div #(
    parameter int N_W   = 8,
    parameter int A_W   = 6,
    parameter int N_RST = 144,
    parameter int A_RST = 34
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tune,
    input  logic [N_W-1:0] n_new,
    input  logic [A_W-1:0] a_new,
    input  logic           div4_new,
    input  logic           cmp_edge,
    input  logic           pre_tick,
    output logic           fb_edge,
    output logic           mod_hi,
    output logic           hold,
    output logic           lo_div4
);
    typedef struct packed {
        logic [N_W-1:0] cnt;
        logic [N_W-1:0] n;
        logic [A_W-1:0] a;
        logic           div4;
        logic           hold;
        logic           edge_hit;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.edge_hit = 1'b0;
        if (tune) begin
            st_d.n    = n_new;
            st_d.a    = a_new;
            st_d.div4 = div4_new;
            st_d.hold = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.hold) begin
            st_d.cnt = '0;
            if (cmp_edge) st_d.hold = 1'b0;
        end else if (pre_tick) begin
            if (st_q.cnt == st_q.n - 1'b1) begin
                st_d.cnt      = '0;
                st_d.edge_hit = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.n    <= N_W'(N_RST);
            st_q.a    <= A_W'(A_RST);
            st_q.div4 <= 1'b1;
            st_q.hold <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign fb_edge = st_q.edge_hit;
    assign mod_hi  = st_q.cnt < {{(N_W-A_W){1'b0}}, st_q.a};
    assign hold    = st_q.hold;
    assign lo_div4 = st_q.div4;

endmodule

// File: rtl/synth_pfd_lock.sv
module synth_pfd_lock #(
    parameter int THR      = 4,
    parameter int LOCK_CNT = 16,
    parameter int WID_W    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_edge,
    input  logic fb_edge,
    input  logic hold,
    input  logic tune,
    output logic up,
    output logic dn,
    output logic lock
);
    import synth_pkg::*;

    localparam int GW = $clog2(LOCK_CNT + 1);

    typedef struct packed {
        pfd_cmd_t       cmd;
        logic [WID_W-1:0] wid;
        logic [GW-1:0]    good;
        logic             lock;
    } st_t;

    st_t              st_d, st_q;
    pfd_cmd_t         cmd_n;
    logic [WID_W-1:0] wid_t;
    logic [GW-1:0]    good_n;

    always_comb begin
        st_d     = st_q;
        cmd_n.up = st_q.cmd.up | cmp_edge;
        cmd_n.dn = st_q.cmd.dn | fb_edge;
        if (cmd_n.up && cmd_n.dn) cmd_n = '0;
        st_d.cmd = cmd_n;
        wid_t = ((st_q.cmd.up || st_q.cmd.dn) && (st_q.wid != '1)) ?
                st_q.wid + 1'b1 : st_q.wid;
        st_d.wid = wid_t;
        good_n   = (st_q.good == GW'(LOCK_CNT)) ? st_q.good : st_q.good + 1'b1;
        if (cmp_edge) begin
            st_d.wid = '0;
            if (wid_t >= WID_W'(THR)) begin
                st_d.good = '0;
                st_d.lock = 1'b0;
            end else begin
                st_d.good = good_n;
                st_d.lock = (good_n == GW'(LOCK_CNT));
            end
        end
        if (hold || tune) st_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign up   = st_q.cmd.up;
    assign dn   = st_q.cmd.dn;
    assign lock = st_q.lock;

endmodule

// File: rtl/synth_divider_chain.sv
module synth_divider_chain #(
    parameter int REF_DIV  = 65,
    parameter int PRE_W    = 6,
    parameter int N_W      = 8,
    parameter int CH_W     = 9,
    parameter int LAST_LO  = 174,
    parameter int LAST_HI  = 374,
    parameter int RX_LO    = 9250,
    parameter int TX_LO    = 8800,
    parameter int RX_HI    = 18050,
    parameter int TX_HI    = 17100,
    parameter int THR      = 4,
    parameter int LOCK_CNT = 16,
    parameter int WID_W    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_tick,
    input  logic            pre_tick,
    input  logic            tune,
    input  logic            band_hi,
    input  logic            tx_sel,
    input  logic [CH_W-1:0] chan,
    output logic            mod_hi,
    output logic            fb_edge,
    output logic            up,
    output logic            dn,
    output logic            lock,
    output logic            lo_div4
);
    localparam int N_RST = RX_LO / (2 ** PRE_W);
    localparam int A_RST = RX_LO % (2 ** PRE_W);

    logic [N_W-1:0]   n_new;
    logic [PRE_W-1:0] a_new;
    logic             div4_new;
    logic             ref_edge;
    logic             hold;

    synth_chan_calc #(
        .CH_W(CH_W), .N_W(N_W), .A_W(PRE_W),
        .LAST_LO(LAST_LO), .LAST_HI(LAST_HI),
        .RX_LO(RX_LO), .TX_LO(TX_LO), .RX_HI(RX_HI), .TX_HI(TX_HI)
    ) u_calc (
        .band_hi(band_hi), .tx_sel(tx_sel), .chan(chan),
        .n_val(n_new), .a_val(a_new), .div4(div4_new)
    );

    synth_ref_div #(.DIV(REF_DIV)) u_ref (
        .clk(clk), .rst_n(rst_n), .tick(ref_tick), .cmp_edge(ref_edge)
    );

    synth_fb_div #(
        .N_W(N_W), .A_W(PRE_W), .N_RST(N_RST), .A_RST(A_RST)
    ) u_fb (
        .clk(clk), .rst_n(rst_n), .tune(tune),
        .n_new(n_new), .a_new(a_new), .div4_new(div4_new),
        .cmp_edge(ref_edge), .pre_tick(pre_tick),
        .fb_edge(fb_edge), .mod_hi(mod_hi), .hold(hold), .lo_div4(lo_div4)
    );

    synth_pfd_lock #(
        .THR(THR), .LOCK_CNT(LOCK_CNT), .WID_W(WID_W)
    ) u_pfd (
        .clk(clk), .rst_n(rst_n), .cmp_edge(ref_edge), .fb_edge(fb_edge),
        .hold(hold), .tune(tune), .up(up), .dn(dn), .lock(lock)
    );

endmodule

// File: rtl/synth_divider_chain_chk.sv
module synth_divider_chain_chk (
    input logic clk,
    input logic rst_n,
    input logic tune,
    input logic ref_edge,
    input logic fb_edge,
    input logic up,
    input logic dn,
    input logic lock
);
    a_r1_single_cmp_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ref_edge |=> !ref_edge);

    a_r4_single_fb_edge: assert property (@(posedge clk) disable iff (!rst_n)
        fb_edge |=> !fb_edge);

    a_r6_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(up && dn));

    a_r7_tune_quiets: assert property (@(posedge clk) disable iff (!rst_n)
        tune |=> (!up && !dn && !fb_edge));

    a_r8_lock_rises_at_compare: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(ref_edge));

    a_r9_tune_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
        tune |=> !lock);

    a_r9_lock_falls_at_event: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock) |-> ($past(ref_edge) || $past(tune)));

endmodule

bind synth_divider_chain synth_divider_chain_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tune(tune), .ref_edge(ref_edge),
    .fb_edge(fb_edge), .up(up), .dn(dn), .lock(lock)
);

// File: tb/tb_synth_divider_chain.sv
module tb_synth_divider_chain;
    localparam int PER  = 260;
    localparam int TICK = 4;

    typedef struct packed {
        logic        band;
        logic        tx;
        logic [8:0]  ch;
        logic [15:0] total;
        logic        div4;
        logic        clamp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 9'd0,   16'd9250, 1'b1, 1'b0},
        '{1'b0, 1'b0, 9'd174, 16'd9598, 1'b1, 1'b0},
        '{1'b0, 1'b1, 9'd0,   16'd8800, 1'b1, 1'b0},
        '{1'b0, 1'b1, 9'd174, 16'd9148, 1'b1, 1'b0},
        '{1'b1, 1'b0, 9'd0,   16'd9025, 1'b0, 1'b0},
        '{1'b1, 1'b0, 9'd374, 16'd9399, 1'b0, 1'b0},
        '{1'b1, 1'b1, 9'd0,   16'd8550, 1'b0, 1'b0},
        '{1'b1, 1'b1, 9'd374, 16'd8924, 1'b0, 1'b0},
        '{1'b0, 1'b0, 9'd500, 16'd9598, 1'b1, 1'b1},
        '{1'b1, 1'b1, 9'd511, 16'd8924, 1'b0, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0, pre_tick = 1'b0, tune = 1'b0;
    logic       band_hi = 1'b0, tx_sel = 1'b0;
    logic [8:0] chan = '0;
    logic       mod_hi, fb_edge, up, dn, lock, lo_div4;

    synth_divider_chain dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pre_tick(pre_tick),
        .tune(tune), .band_hi(band_hi), .tx_sel(tx_sel), .chan(chan),
        .mod_hi(mod_hi), .fb_edge(fb_edge), .up(up), .dn(dn),
        .lock(lock), .lo_div4(lo_div4)
    );

    always #4 clk = ~clk;

    int  checks = 0, fails = 0;
    int  t = 0;
    int  mode = 0, shift = 0, nfr = 0;
    int  gap = 0, acnt = 0, last_n = 0, last_a = 0;
    int  dn_win = 0, up_win = 0, last_dn = 0, last_up = 0;
    int  hv_lo = -1, hv_hi = -1, hold_viol = 0;
    int  t_tune = 0, b0 = 0, mark = 0;
    bit  done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input bit tn);
        int phase;
        phase    = (t + shift) % PER;
        ref_tick = (t % TICK) == TICK - 1;
        pre_tick = (mode == 1) ? 1'b1 : (mode == 2) ? (phase >= PER - nfr) : 1'b0;
        tune     = tn;
        if (fb_edge) begin
            last_n = gap; last_a = acnt; gap = 0; acnt = 0;
        end
        if (pre_tick) begin
            gap++;
            if (mod_hi) acnt++;
        end
        if (t % PER == 1) begin dn_win = 0; up_win = 0; end
        dn_win += int'(dn);
        up_win += int'(up);
        if (t % PER == 0) begin last_dn = dn_win; last_up = up_win; end
        if (t >= hv_lo && t <= hv_hi && (fb_edge || up || dn)) hold_viol++;
        @(negedge clk);
        t++;
    endtask

    task automatic run_to(input int target);
        while (t < target) step(1'b0);
    endtask

    task automatic retune(input logic b, input logic x, input logic [8:0] c);
        while (t % PER != 100) step(1'b0);
        band_hi = b; tx_sel = x; chan = c;
        t_tune = t;
        b0 = (t / PER + 1) * PER;
        hv_lo = t + 1; hv_hi = b0 + 1;
        step(1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        check(up == 0 && dn == 0, "R10 up/dn after reset", int'({up, dn}), 0);
        check(lock == 0, "R10 lock after reset", int'(lock), 0);
        check(fb_edge == 0, "R10 fb_edge after reset", int'(fb_edge), 0);
        check(lo_div4 == 1, "R10 lo_div4 after reset", int'(lo_div4), 1);
        check(mod_hi == 1, "R10 mod_hi after reset", int'(mod_hi), 1);

        // table walk: continuous prescaler pulses, measure N and A
        for (int i = 0; i < NV; i++) begin
            mode = 1;
            hold_viol = 0;
            retune(VECS[i].band, VECS[i].tx, VECS[i].ch);
            run_to(t + 3 * PER);
            if (VECS[i].clamp)
                check(last_n * 64 + last_a == int'(VECS[i].total), "R3 clamped total",
                      last_n * 64 + last_a, int'(VECS[i].total));
            else
                check(last_n * 64 + last_a == int'(VECS[i].total), "R2 total division",
                      last_n * 64 + last_a, int'(VECS[i].total));
            check(last_n == int'(VECS[i].total) / 64 && last_a == int'(VECS[i].total) % 64,
                  "R4 N/A split", last_n * 100 + last_a,
                  (int'(VECS[i].total) / 64) * 100 + int'(VECS[i].total) % 64);
            check(lo_div4 == VECS[i].div4, "R5 post-divider select",
                  int'(lo_div4), int'(VECS[i].div4));
            check(hold_viol == 0, "R7 quiet during hold", hold_viol, 0);
        end
        hv_lo = -1; hv_hi = -1;

        // aligned loop: lock after 16 good comparisons
        mode = 2; shift = 0; nfr = 144;
        retune(1'b0, 1'b0, 9'd0);
        check(lock == 0, "R9 lock low after tune", int'(lock), 0);
        run_to(b0 + 15 * PER + 130);
        check(lock == 0, "R8 no lock after 15", int'(lock), 0);
        check(last_up == 0 && last_dn == 0, "R1 R6 aligned edges give no pulse",
              last_up + last_dn, 0);
        run_to(b0 + 16 * PER + 130);
        check(lock == 1, "R8 lock after 16", int'(lock), 1);

        // lead by 3: dn width 3, lock kept
        run_to((t / PER + 1) * PER);
        shift = 3; mark = t;
        run_to(mark + PER + 130);
        check(last_dn == 3 && last_up == 0, "R6 dn width for 3-cycle lead",
              last_dn, 3);
        check(lock == 1, "R8 lock kept below threshold", int'(lock), 1);

        // lead by 4: first violation drops lock
        run_to((t / PER + 1) * PER);
        shift = 4; mark = t;
        run_to(mark + 130);
        check(lock == 1, "R9 lock before violation", int'(lock), 1);
        run_to(mark + PER + 130);
        check(last_dn == 4, "R6 dn width for 4-cycle lead", last_dn, 4);
        check(lock == 0, "R9 lock drops on first violation", int'(lock), 0);

        // realign: count restarts from zero
        run_to((t / PER + 1) * PER);
        shift = 0; mark = t;
        run_to(mark + 15 * PER + 130);
        check(lock == 0, "R8 relock not after 15", int'(lock), 0);
        run_to(mark + 16 * PER + 130);
        check(lock == 1, "R8 relock after 16", int'(lock), 1);

        // retune while locked
        retune(1'b0, 1'b0, 9'd0);
        check(lock == 0, "R9 tune clears lock", int'(lock), 0);
        check(up == 0 && dn == 0, "R7 tune clears pump commands", int'({up, dn}), 0);

        // slow feedback: lag gives up pulses and no lock
        nfr = 143;
        run_to(b0 + 5 * PER + 130);
        check(last_up > 0, "R6 lagging feedback drives up", last_up, 1);
        check(lock == 0, "R9 no lock with frequency error", int'(lock), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule